// File: doc/BRIEF.md
# Serial Configuration Loader with Cascade Handoff

This block takes a programmable-logic configuration stream that arrives one bit at a time on a serial data pin. It packs the bits into bytes and hands each payload byte to an internal configuration-write port as a one-cycle strobe. Three strap pins select how the bit clock is obtained. In master mode the loader generates its own configuration clock from the system clock, at one of four rates. In the two slave modes an external agent drives the configuration clock, and one of those two slave modes also needs an active-low chip select before any bit is taken.

The stream begins with a 16-bit big-endian count of the payload bytes that follow it. When the last counted byte has been written, the loader raises its done flag and pulls its cascade chip-select output low. That output lets the next device in a daisy chain start its own load. An active-low reset clears the loader and holds the ready indication low. The reset also latches the strap pins and the rate option. All logic runs on one system clock, and the external configuration clock, serial data and chip select are brought in through a synchronizer.

Top module: `serial_cfg_loader`

## Requirements
- R1: While `rst_n` is low, `init_o` is 0, `cfg_done` is 0, `cs_out_n` is 1 and `wr_stb` is 0. `init_o` reads 1 after the first rising `clk` edge at which `rst_n` is high.
- R2: With `mode_sel` = 3'b111, bits are taken on rising edges of `ext_cclk` regardless of `cs_in_n`, and `cclk_out` stays 0.
- R3: Payload bits are packed most significant bit first. Every eighth payload bit produces exactly one cycle of `wr_stb` with the assembled byte on `wr_data`.
- R4: The first two bytes of the stream form the payload count, high byte first. These header bytes produce no `wr_stb`, and `cfg_done` stays 0 until the counted number of payload bytes has been strobed.
- R5: Once `cfg_done` is 1, it and `cs_out_n` = 0 hold until reset. Any bits that arrive afterwards produce no `wr_stb`.
- R6: With `mode_sel` = 3'b001, clock edges that arrive while `cs_in_n` is 1 are ignored and leave the header and byte position untouched. Edges that arrive while `cs_in_n` is 0 load as in R2.
- R7: With `mode_sel` = 3'b000, `cclk_out` is generated internally with a period of 16, 8, 4 or 2 `clk` cycles for `rate_sel` = 00, 01, 10 or 11 respectively.
- R8: In master mode, `ser_data` is sampled at each rising edge of `cclk_out`, and a full stream loads as in R3 and R4.
- R9: Any `mode_sel` encoding other than 000, 001 or 111 keeps the loader idle: `cclk_out` stays 0, `wr_stb` stays 0 and `cfg_done` stays 0.
- R10: `mode_sel` and `rate_sel` are captured only while `rst_n` is low. Later changes on them have no effect until the next reset.
- R11: A payload count of zero sets `cfg_done` and `cs_out_n` = 0 directly after the second header byte, with no `wr_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (16 MHz nominal) |
| rst_n | input | 1 | Active-low reset; also latches the strap pins |
| mode_sel | input | 3 | Strap pins: 000 master, 001 slave with chip select, 111 slave without |
| rate_sel | input | 2 | Master clock rate option, 00 slowest to 11 fastest |
| ext_cclk | input | 1 | External configuration clock in slave modes |
| ser_data | input | 1 | Serial configuration data |
| cs_in_n | input | 1 | Active-low chip select, used in mode 001 |
| cclk_out | output | 1 | Internally generated configuration clock in master mode |
| init_o | output | 1 | Ready indication, low during reset |
| wr_data | output | 8 | Assembled payload byte |
| wr_stb | output | 1 | One-cycle write strobe for `wr_data` |
| cfg_done | output | 1 | Load complete |
| cs_out_n | output | 1 | Active-low chip select handed to the next device in the cascade |

## Verification
The bench builds the loader with its defaults: a base divide of 16, a two-stage input synchronizer, 8-bit bytes and a 16-bit count. These values make all four master clock periods measurable within a short run. The slow external clock (eight system cycles per bit) clears the synchronizer latency comfortably. With the 16-bit count, the two-byte header, the zero-count path and the cascade handoff can all be exercised with streams of only a few bytes.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    typedef enum logic [1:0] {
        MODE_OFF,
        MODE_MASTER,
        MODE_SLAVE_CS,
        MODE_SLAVE_FREE
    } load_mode_t;

    typedef enum logic [1:0] {
        PH_LEN,
        PH_DATA,
        PH_DONE
    } phase_t;

    // Strap decode; unlisted encodings map to the idle mode.
    function automatic load_mode_t decode_straps(input logic [2:0] straps);
        case (straps)
            3'b000:  return MODE_MASTER;
            3'b001:  return MODE_SLAVE_CS;
            3'b111:  return MODE_SLAVE_FREE;
            default: return MODE_OFF;
        endcase
    endfunction

endpackage

// File: rtl/cfgld_master_clk.sv
module cfgld_master_clk #(
    parameter int DIV_BASE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic [1:0] rate,
    output logic       cclk_o,
    output logic       tick_o
);
    localparam int CNT_W = $clog2(DIV_BASE);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             level;
    } mclk_t;

    mclk_t cur_q, nxt_d;
    logic [CNT_W-1:0] half_m1;

    always_comb begin
        half_m1 = CNT_W'((DIV_BASE >> 1) >> rate) - CNT_W'(1);
        nxt_d   = cur_q;
        tick_o  = 1'b0;
        if (!enable) begin
            nxt_d = '0;
        end else if (cur_q.cnt == half_m1) begin
            nxt_d.cnt   = '0;
            nxt_d.level = ~cur_q.level;
            tick_o      = ~cur_q.level;
        end else begin
            nxt_d.cnt = cur_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign cclk_o = cur_q.level;

endmodule

// File: rtl/cfgld_slave_sync.sv
module cfgld_slave_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cclk_i,
    input  logic data_i,
    input  logic cs_n_i,
    output logic edge_o,
    output logic data_o,
    output logic sel_o
);
    typedef struct packed {
        logic cclk;
        logic dat;
        logic cs_n;
    } pin_t;

    localparam pin_t PIN_IDLE = '{cclk: 1'b0, dat: 1'b0, cs_n: 1'b1};

    typedef struct packed {
        pin_t [STAGES:0] pipe;
    } sync_t;

    sync_t cur_q, nxt_d;

    always_comb begin
        nxt_d.pipe[0] = '{cclk: cclk_i, dat: data_i, cs_n: cs_n_i};
        for (int i = 1; i <= STAGES; i++) begin
            nxt_d.pipe[i] = cur_q.pipe[i-1];
        end
    end

    generate
        for (genvar g = 0; g <= STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) cur_q.pipe[g] <= PIN_IDLE;
                else        cur_q.pipe[g] <= nxt_d.pipe[g];
            end
        end
    endgenerate

    assign edge_o = cur_q.pipe[STAGES-1].cclk & ~cur_q.pipe[STAGES].cclk;
    assign data_o = cur_q.pipe[STAGES-1].dat;
    assign sel_o  = ~cur_q.pipe[STAGES-1].cs_n;

endmodule

// File: rtl/cfgld_assembler.sv
module cfgld_assembler
    import cfgld_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              bit_val,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_stb,
    output logic              done
);
    localparam int HDR_BYTES = LEN_W / BYTE_W;
    localparam int BCNT_W    = $clog2(BYTE_W);
    localparam int HCNT_W    = (HDR_BYTES > 1) ? $clog2(HDR_BYTES) : 1;

    typedef struct packed {
        phase_t            phase;
        logic [BYTE_W-1:0] shift;
        logic [BCNT_W-1:0] bcnt;
        logic [HCNT_W-1:0] hcnt;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  seen;
        logic [BYTE_W-1:0] wdata;
        logic              stb;
        logic              done;
    } asm_t;

    asm_t cur_q, nxt_d;
    logic [BYTE_W-1:0]       full;
    logic [LEN_W+BYTE_W-1:0] len_cat;
    logic [LEN_W-1:0]        len_n;
    logic [LEN_W-1:0]        seen_n;
    logic                    byte_end;

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.stb = 1'b0;
        full     = {cur_q.shift[BYTE_W-2:0], bit_val};
        len_cat  = {cur_q.len, full};
        len_n    = len_cat[LEN_W-1:0];
        seen_n   = cur_q.seen + LEN_W'(1);
        byte_end = (cur_q.bcnt == BCNT_W'(BYTE_W - 1));

        if (bit_vld && cur_q.phase != PH_DONE) begin
            nxt_d.shift = full;
            nxt_d.bcnt  = byte_end ? '0 : cur_q.bcnt + BCNT_W'(1);
            if (byte_end) begin
                case (cur_q.phase)
                    PH_LEN: begin
                        nxt_d.len = len_n;
                        if (cur_q.hcnt == HCNT_W'(HDR_BYTES - 1)) begin
                            if (len_n == '0) begin
                                nxt_d.phase = PH_DONE;
                                nxt_d.done  = 1'b1;
                            end else begin
                                nxt_d.phase = PH_DATA;
                            end
                        end else begin
                            nxt_d.hcnt = cur_q.hcnt + HCNT_W'(1);
                        end
                    end
                    PH_DATA: begin
                        nxt_d.wdata = full;
                        nxt_d.stb   = 1'b1;
                        nxt_d.seen  = seen_n;
                        if (seen_n == cur_q.len) begin
                            nxt_d.phase = PH_DONE;
                            nxt_d.done  = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.phase <= PH_LEN;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign wr_data = cur_q.wdata;
    assign wr_stb  = cur_q.stb;
    assign done    = cur_q.done;

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
    import cfgld_pkg::*;
#(
    parameter int DIV_BASE    = 16,
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_W      = 8,
    parameter int LEN_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_sel,
    input  logic [1:0]        rate_sel,
    input  logic              ext_cclk,
    input  logic              ser_data,
    input  logic              cs_in_n,
    output logic              cclk_out,
    output logic              init_o,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_stb,
    output logic              cfg_done,
    output logic              cs_out_n
);
    typedef struct packed {
        load_mode_t mode;
        logic [1:0] rate;
        logic       init;
    } top_t;

    top_t       cur_q, nxt_d;
    load_mode_t mode_q;
    logic       m_tick, s_edge, s_data, s_sel;
    logic       bit_vld, bit_val;
    logic       done_w;

    always_comb begin
        nxt_d = cur_q;
        if (!rst_n) begin
            nxt_d.mode = decode_straps(mode_sel);
            nxt_d.rate = rate_sel;
            nxt_d.init = 1'b0;
        end else begin
            nxt_d.init = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end

    assign mode_q = cur_q.mode;

    cfgld_master_clk #(.DIV_BASE(DIV_BASE)) u_mclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (mode_q == MODE_MASTER),
        .rate   (cur_q.rate),
        .cclk_o (cclk_out),
        .tick_o (m_tick)
    );

    cfgld_slave_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .cclk_i (ext_cclk),
        .data_i (ser_data),
        .cs_n_i (cs_in_n),
        .edge_o (s_edge),
        .data_o (s_data),
        .sel_o  (s_sel)
    );

    always_comb begin
        case (mode_q)
            MODE_MASTER:     begin bit_vld = m_tick;          bit_val = ser_data; end
            MODE_SLAVE_FREE: begin bit_vld = s_edge;          bit_val = s_data;   end
            MODE_SLAVE_CS:   begin bit_vld = s_edge & s_sel;  bit_val = s_data;   end
            default:         begin bit_vld = 1'b0;            bit_val = 1'b0;     end
        endcase
    end

    cfgld_assembler #(.BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_asm (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_vld (bit_vld),
        .bit_val (bit_val),
        .wr_data (wr_data),
        .wr_stb  (wr_stb),
        .done    (done_w)
    );

    assign init_o   = cur_q.init;
    assign cfg_done = done_w;
    assign cs_out_n = ~done_w;

endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker
    import cfgld_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input load_mode_t mode_q,
    input logic       cclk_out,
    input logic       init_o,
    input logic       wr_stb,
    input logic       cfg_done,
    input logic       cs_out_n
);
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (!init_o && !cfg_done && cs_out_n && !wr_stb)); // R1

    AST_INIT_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        !init_o |=> init_o); // R1

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R3

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> (cfg_done && !cs_out_n)); // R5

    AST_NO_STB_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_done) |-> !wr_stb); // R5

    AST_SLAVE_NO_CCLK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SLAVE_CS || mode_q == MODE_SLAVE_FREE) |-> !cclk_out); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_OFF) |-> (!cclk_out && !wr_stb && !cfg_done)); // R9

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode_q)); // R10
endmodule

bind serial_cfg_loader cfgld_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_q   (mode_q),
    .cclk_out (cclk_out),
    .init_o   (init_o),
    .wr_stb   (wr_stb),
    .cfg_done (cfg_done),
    .cs_out_n (cs_out_n)
);

// File: tb/serial_cfg_loader_test.sv
module serial_cfg_loader_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_sel = 3'b111;
    logic [1:0] rate_sel = 2'b00;
    logic       ext_cclk = 1'b0;
    logic       ser_data = 1'b0;
    logic       cs_in_n = 1'b1;
    logic       cclk_out, init_o, wr_stb, cfg_done, cs_out_n;
    logic [7:0] wr_data;

    int tests = 0;
    int fails = 0;
    int cap_n = 0;
    logic [7:0] cap [0:63];

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_cfg_loader uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .rate_sel(rate_sel),
        .ext_cclk(ext_cclk), .ser_data(ser_data), .cs_in_n(cs_in_n),
        .cclk_out(cclk_out), .init_o(init_o), .wr_data(wr_data),
        .wr_stb(wr_stb), .cfg_done(cfg_done), .cs_out_n(cs_out_n)
    );

    always @(negedge clk) begin
        if (rst_n && wr_stb && cap_n < 64) begin
            cap[cap_n] = wr_data;
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] m, input logic [1:0] r);
        @(negedge clk);
        rst_n = 1'b0; mode_sel = m; rate_sel = r;
        ext_cclk = 1'b0; ser_data = 1'b0; cs_in_n = 1'b1;
        repeat (3) @(negedge clk);
        cap_n = 0;
        rst_n = 1'b1;
    endtask

    task automatic slave_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            ser_data = b[i]; ext_cclk = 1'b0;
            repeat (4) @(negedge clk);
            ext_cclk = 1'b1;
            repeat (4) @(negedge clk);
        end
        ext_cclk = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic master_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            do @(negedge clk); while (cclk_out !== 1'b0);
            ser_data = b[i];
            do @(negedge clk); while (cclk_out !== 1'b1);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0; mode_sel = 3'b111;
        repeat (3) @(negedge clk);
        chk("R1 init low in reset", init_o, 1'b0);
        chk("R1 done low in reset", cfg_done, 1'b0);
        chk("R1 cs_out_n high in reset", cs_out_n, 1'b1);
        chk("R1 strobe low in reset", wr_stb, 1'b0);
        rst_n = 1'b1;
        chk("R1 init still low at release", init_o, 1'b0);
        @(negedge clk);
        chk("R1 init high one cycle later", init_o, 1'b1);
    endtask

    task automatic t_slave_free;
        do_reset(3'b111, 2'b00);
        cs_in_n = 1'b1;
        slave_byte(8'h00); slave_byte(8'h03);
        chk("R4 header gives no strobe", cap_n, 0);
        slave_byte(8'hA5); slave_byte(8'h3C);
        chk("R4 done low before count reached", cfg_done, 1'b0);
        chk("R2 cclk_out low in slave", cclk_out, 1'b0);
        slave_byte(8'h0F);
        chk("R3 three bytes strobed", cap_n, 3);
        chk("R3 byte0 msb first", cap[0], 8'hA5);
        chk("R3 byte1", cap[1], 8'h3C);
        chk("R3 byte2", cap[2], 8'h0F);
        chk("R4 done at count", cfg_done, 1'b1);
        chk("R5 cascade select low", cs_out_n, 1'b0);
        slave_byte(8'hFF);
        chk("R5 extra bits not strobed", cap_n, 3);
        chk("R5 done held", cfg_done, 1'b1);
    endtask

    task automatic t_slave_cs;
        do_reset(3'b001, 2'b00);
        cs_in_n = 1'b1;
        slave_byte(8'h00); slave_byte(8'h05); slave_byte(8'hEE);
        chk("R6 no strobe without select", cap_n, 0);
        chk("R6 no done without select", cfg_done, 1'b0);
        cs_in_n = 1'b0;
        slave_byte(8'h00); slave_byte(8'h01); slave_byte(8'h81);
        chk("R6 one byte with select", cap_n, 1);
        chk("R6 byte value", cap[0], 8'h81);
        chk("R6 done with select", cfg_done, 1'b1);
    endtask

    task automatic t_zero_len;
        do_reset(3'b111, 2'b00);
        slave_byte(8'h00); slave_byte(8'h00);
        chk("R11 done after zero header", cfg_done, 1'b1);
        chk("R11 cascade low", cs_out_n, 1'b0);
        chk("R11 no strobe", cap_n, 0);
    endtask

    task automatic t_master_rates;
        int n;
        for (int r = 0; r < 4; r++) begin
            do_reset(3'b000, 2'(r));
            do @(negedge clk); while (cclk_out !== 1'b1);
            n = 0;
            do begin @(negedge clk); n++; end while (cclk_out !== 1'b0);
            do begin @(negedge clk); n++; end while (cclk_out !== 1'b1);
            chk($sformatf("R7 master period rate %0d", r), n, 16 >> r);
        end
    endtask

    task automatic t_master_load;
        do_reset(3'b000, 2'b10);
        master_byte(8'h00); master_byte(8'h02);
        master_byte(8'hC3); master_byte(8'h5A);
        repeat (2) @(negedge clk);
        chk("R8 master two bytes", cap_n, 2);
        chk("R8 master byte0", cap[0], 8'hC3);
        chk("R8 master byte1", cap[1], 8'h5A);
        chk("R8 master done", cfg_done, 1'b1);
    endtask

    task automatic t_bad_mode;
        logic saw_clk;
        do_reset(3'b010, 2'b11);
        saw_clk = 1'b0;
        fork
            begin
                slave_byte(8'h00); slave_byte(8'h01); slave_byte(8'h99);
            end
            begin
                repeat (200) begin
                    @(negedge clk);
                    if (cclk_out !== 1'b0) saw_clk = 1'b1;
                end
            end
        join
        chk("R9 no internal clock", saw_clk, 1'b0);
        chk("R9 no strobe", cap_n, 0);
        chk("R9 no done", cfg_done, 1'b0);
    endtask

    task automatic t_mode_latch;
        do_reset(3'b111, 2'b00);
        @(negedge clk);
        mode_sel = 3'b010; rate_sel = 2'b11;
        slave_byte(8'h00); slave_byte(8'h01); slave_byte(8'h77);
        chk("R10 load after strap change", cap_n, 1);
        chk("R10 byte value", cap[0], 8'h77);
        chk("R10 done", cfg_done, 1'b1);
        chk("R10 no internal clock", cclk_out, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_slave_free();
        t_slave_cs();
        t_zero_len();
        t_master_rates();
        t_master_load();
        t_bad_mode();
        t_mode_latch();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule